// File: doc/BRIEF.md
# Job Slot Activity Counter Unit

This block keeps cycle and event counts for a job dispatcher with a small number of job slots (three by default). Every clock it looks at a set of status flags: a per-slot "work queued" vector, a profiling cycle-count enable, a per-slot "chain running" vector and an "interrupt awaiting service" flag. It also looks at a per-slot pulse that marks a task handed to a worker unit. From these it keeps one overall-active cycle count, one active cycle count per slot, one interrupt-pending cycle count and one task count per slot.

The overall-active count depends only on queued work and the profiling enable. It does not depend on whether a chain is making progress, so a job stalled on memory is still counted as active time. On slot 0 each task stands for one screen region of 16x16 or 32x32 pixels, depending on how the dispatcher is configured. The counter adds one per task whatever the region size. Software selects a counter with a 3-bit index and reads its value one cycle later. A one-cycle clear input zeroes every counter at once. All counters saturate rather than wrap.

Top module: `jsc_top`

## Requirements
- R1: The overall-active counter (index 0) gains one in every cycle in which any bit of `work_queued_i` is high or `prof_cnt_en_i` is high, and holds its value in cycles where all of these are low.
- R2: The overall-active counter counts while work is queued even if no chain is running and no task is issued (a memory stall), and it also counts on `prof_cnt_en_i` alone.
- R3: Slot s has an active counter (index 1+s: slot 0 at 1, slot 1 at 2, slot 2 at 3) that gains one in every cycle where `chain_run_i[s]` is high, independently of the other slots.
- R4: The interrupt-pending counter (index 4) gains one in every cycle where `irq_pend_i` is high, and the slot counters keep counting independently during those cycles.
- R5: Slot s has a task counter (index 5+s: slot 0 at 5, slot 1 at 6, slot 2 at 7) that gains exactly one for each cycle in which `task_issue_i[s]` is high. A slot 0 task is one screen region.
- R6: Every counter is CNT_W bits wide (32 by default) and stops at the all-ones value instead of wrapping.
- R7: When `clr_i` is high at a clock edge, every counter is zero after that edge, even if an event for that counter is present in the same cycle.
- R8: `rd_data_o` takes, at the clock edge that samples `rd_idx_i`, the value the selected counter held just before that edge. It therefore shows the value one cycle after the index is presented.
- R9: After a synchronous active-low reset, every counter and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| work_queued_i | input | NUM_SLOTS | Per-slot flag: work is queued in the slot |
| prof_cnt_en_i | input | 1 | Profiling cycle count is running |
| chain_run_i | input | NUM_SLOTS | Per-slot flag: a job chain is running |
| irq_pend_i | input | 1 | An interrupt is awaiting service |
| task_issue_i | input | NUM_SLOTS | Per-slot pulse: one task issued this cycle |
| clr_i | input | 1 | Clear all counters (one cycle) |
| rd_idx_i | input | IDX_W | Counter index to read |
| rd_data_o | output | CNT_W | Selected counter value, one cycle after the index |

## Verification
A clear and a counting event can land in the same cycle. The bench provokes this by raising `clr_i` together with every status flag and task pulse for one cycle after the counters have been loaded. It then reads all eight counters and expects zero from each. Saturation and a new event also meet: with a narrow counter width, the overall-active counter is driven for more cycles than it can hold and must read all-ones. A read issued while a counter is still incrementing must return the value from before that edge.

// File: rtl/jsc_pkg.sv
// Package: shared defaults and counter index layout for the job slot
// activity counter unit. Assumes the index layout is a pure function of
// the slot count.
package jsc_pkg;

    localparam int unsigned DEF_SLOTS = 3;
    localparam int unsigned DEF_CNT_W = 32;

    // Total number of counters for a given slot count.
    function automatic int unsigned num_counters(input int unsigned slots);
        return 2 + 2 * slots;
    endfunction

    // Index of the overall-active counter.
    function automatic int unsigned idx_overall();
        return 0;
    endfunction

    // Index of the active counter of a slot.
    function automatic int unsigned idx_slot_active(input int unsigned slots, input int unsigned s);
        return 1 + (s % slots);
    endfunction

    // Index of the interrupt-pending counter.
    function automatic int unsigned idx_irq(input int unsigned slots);
        return 1 + slots;
    endfunction

    // Index of the task counter of a slot.
    function automatic int unsigned idx_slot_task(input int unsigned slots, input int unsigned s);
        return 2 + slots + (s % slots);
    endfunction

endpackage

// File: rtl/jsc_event_qual.sv
// Event qualifier: turns the raw dispatcher flags into one increment
// request per counter. Purely combinational. Assumes the inputs are
// synchronous to the counter clock.
module jsc_event_qual
    import jsc_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    localparam int unsigned NCNT = num_counters(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] work_queued_i,
    input  logic                 prof_cnt_en_i,
    input  logic [NUM_SLOTS-1:0] chain_run_i,
    input  logic                 irq_pend_i,
    input  logic [NUM_SLOTS-1:0] task_issue_i,
    output logic [NCNT-1:0]      inc_o
);

    // Overall activity: any queued work or the profiling count enable.
    assign inc_o[idx_overall()] = (|work_queued_i) | prof_cnt_en_i;

    // Interrupt pending cycles.
    assign inc_o[idx_irq(NUM_SLOTS)] = irq_pend_i;

    // Per-slot active and task requests.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign inc_o[idx_slot_active(NUM_SLOTS, s)] = chain_run_i[s];
        assign inc_o[idx_slot_task(NUM_SLOTS, s)]   = task_issue_i[s];
    end

endmodule

// File: rtl/jsc_sat_counter.sv
// Saturating up-counter with a synchronous clear that takes priority over
// an increment. Assumes at most one increment per cycle.
module jsc_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count state: reset, clear, or step by one below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != MAXV)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R7

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_o == MAXV) |=> (cnt_o == MAXV)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_o)); // R1

endmodule

// File: rtl/jsc_read_port.sv
// Registered read port: samples the counter index and returns the chosen
// counter one cycle later. Assumes counters are given as a packed array.
module jsc_read_port #(
    parameter int unsigned NCNT  = 8,
    parameter int unsigned W     = 32,
    localparam int unsigned IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx_i,
    input  logic [NCNT-1:0][W-1:0] cnt_i,
    output logic [W-1:0]           rd_data_o
);

    logic [W-1:0] sel_val;

    // Select: full index space needs no range check; otherwise return zero.
    if (NCNT == (2 ** IDX_W)) begin : g_full
        assign sel_val = cnt_i[rd_idx_i];
    end else begin : g_partial
        always_comb begin
            sel_val = '0;
            for (int i = 0; i < NCNT; i++) begin
                if (rd_idx_i == IDX_W'(i)) sel_val = cnt_i[i];
            end
        end
    end

    // Output register for the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_o <= '0;
        else        rd_data_o <= sel_val;
    end

endmodule

// File: rtl/jsc_top.sv
// Job slot activity counter unit: overall-active, per-slot active,
// interrupt-pending and per-slot task counters with a shared clear and a
// one-cycle-latency read port. Assumes all inputs are synchronous.
module jsc_top
    import jsc_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned NCNT  = num_counters(NUM_SLOTS),
    localparam int unsigned IDX_W = $clog2(NCNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] work_queued_i,
    input  logic                 prof_cnt_en_i,
    input  logic [NUM_SLOTS-1:0] chain_run_i,
    input  logic                 irq_pend_i,
    input  logic [NUM_SLOTS-1:0] task_issue_i,
    input  logic                 clr_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [CNT_W-1:0]     rd_data_o
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [NCNT-1:0]            inc;
    logic [NCNT-1:0][CNT_W-1:0] cnt;

    jsc_event_qual #(.NUM_SLOTS(NUM_SLOTS)) u_qual (
        .work_queued_i (work_queued_i),
        .prof_cnt_en_i (prof_cnt_en_i),
        .chain_run_i   (chain_run_i),
        .irq_pend_i    (irq_pend_i),
        .task_issue_i  (task_issue_i),
        .inc_o         (inc)
    );

    // One saturating counter per event source.
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        jsc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (inc[i]),
            .cnt_o (cnt[i])
        );
    end

    jsc_read_port #(.NCNT(NCNT), .W(CNT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (rd_idx_i),
        .cnt_i     (cnt),
        .rd_data_o (rd_data_o)
    );

    AST_OVERALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ((|work_queued_i) || prof_cnt_en_i) && cnt[idx_overall()] != MAXV)
        |=> (cnt[idx_overall()] == CNT_W'($past(cnt[idx_overall()]) + 1'b1))); // R2

    AST_IRQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && irq_pend_i && cnt[idx_irq(NUM_SLOTS)] != MAXV)
        |=> (cnt[idx_irq(NUM_SLOTS)] == CNT_W'($past(cnt[idx_irq(NUM_SLOTS)]) + 1'b1))); // R4

    AST_SLOT0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && chain_run_i[0] && cnt[idx_slot_active(NUM_SLOTS, 0)] != MAXV)
        |=> (cnt[idx_slot_active(NUM_SLOTS, 0)] ==
             CNT_W'($past(cnt[idx_slot_active(NUM_SLOTS, 0)]) + 1'b1))); // R3

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |=> (rd_data_o == '0)); // R8

endmodule

// File: tb/jsc_top_tb_top.sv
// Directed bench for the job slot activity counter unit.
module jsc_top_tb_top;

    localparam int NS = 3;
    localparam int W  = 8;
    localparam int MAXV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] work_queued = '0;
    logic          prof_en = 1'b0;
    logic [NS-1:0] chain_run = '0;
    logic          irq_pend = 1'b0;
    logic [NS-1:0] task_issue = '0;
    logic          clr = 1'b0;
    logic [2:0]    rd_idx = '0;
    logic [W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    jsc_top #(.NUM_SLOTS(NS), .CNT_W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .work_queued_i (work_queued),
        .prof_cnt_en_i (prof_en),
        .chain_run_i   (chain_run),
        .irq_pend_i    (irq_pend),
        .task_issue_i  (task_issue),
        .clr_i         (clr),
        .rd_idx_i      (rd_idx),
        .rd_data_o     (rd_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        work_queued = '0; prof_en = 1'b0; chain_run = '0;
        irq_pend = 1'b0; task_issue = '0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_cnt(input int idx, output int val);
        @(negedge clk);
        rd_idx = 3'(idx);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic expect_cnt(input string req, input int idx, input int exp);
        int v;
        read_cnt(idx, v);
        check(req, $sformatf("counter %0d", idx), v, exp);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // R9: reset state.
    task automatic t_reset();
        check("R9", "rd_data after reset", int'(rd_data), 0);
        for (int i = 0; i < 8; i++) expect_cnt("R9", i, 0);
    endtask

    // R1/R2: overall activity from queued work (stall) and profiling enable.
    task automatic t_overall();
        do_clear();
        work_queued = 3'b010;
        run(5);
        idle_inputs();
        expect_cnt("R2", 0, 5);
        expect_cnt("R2", 1, 0);
        prof_en = 1'b1;
        run(4);
        idle_inputs();
        expect_cnt("R2", 0, 9);
        run(3);
        expect_cnt("R1", 0, 9);
    endtask

    // R3: per-slot active counters.
    task automatic t_slots();
        do_clear();
        chain_run = 3'b001; run(3);
        chain_run = 3'b110; run(4);
        chain_run = 3'b111; run(2);
        idle_inputs();
        expect_cnt("R3", 1, 5);
        expect_cnt("R3", 2, 6);
        expect_cnt("R3", 3, 6);
        expect_cnt("R1", 0, 0);
    endtask

    // R4: interrupt pending alongside slot activity.
    task automatic t_irq();
        do_clear();
        irq_pend = 1'b1;
        chain_run = 3'b100;
        run(6);
        idle_inputs();
        expect_cnt("R4", 4, 6);
        expect_cnt("R4", 3, 6);
        expect_cnt("R4", 1, 0);
    endtask

    // R5: task counters.
    task automatic t_tasks();
        do_clear();
        task_issue = 3'b001; run(2);
        task_issue = 3'b011; run(3);
        task_issue = 3'b100; run(1);
        idle_inputs();
        expect_cnt("R5", 5, 5);
        expect_cnt("R5", 6, 3);
        expect_cnt("R5", 7, 1);
    endtask

    // R6: saturation at all-ones.
    task automatic t_sat();
        do_clear();
        work_queued = 3'b001;
        irq_pend = 1'b1;
        run(10);
        irq_pend = 1'b0;
        run(290);
        idle_inputs();
        expect_cnt("R6", 0, MAXV);
        expect_cnt("R6", 4, 10);
    endtask

    // R7: clear collides with events on every counter.
    task automatic t_clear_collide();
        do_clear();
        work_queued = 3'b111; chain_run = 3'b111; irq_pend = 1'b1; task_issue = 3'b111;
        run(4);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        idle_inputs();
        for (int i = 0; i < 8; i++) expect_cnt("R7", i, 0);
    endtask

    // R8: read returns the value held before the sampling edge.
    task automatic t_read_latency();
        do_clear();
        @(negedge clk);
        chain_run = 3'b001;
        rd_idx = 3'd1;
        @(negedge clk);
        check("R8", "read at first counting edge", int'(rd_data), 0);
        @(negedge clk);
        check("R8", "read at second counting edge", int'(rd_data), 1);
        chain_run = 3'b000;
        @(negedge clk);
        check("R8", "read after counting stops", int'(rd_data), 2);
        rd_idx = 3'd0;
        #1;
        check("R8", "output before index edge", int'(rd_data), 2);
        @(negedge clk);
        check("R8", "output after index edge", int'(rd_data), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overall();
        t_slots();
        t_irq();
        t_tasks();
        t_sat();
        t_clear_collide();
        t_read_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule